// File: doc/BRIEF.md
# Bit-Serial I/O Bus Controller

This block carries out the I/O side of a 16-bit processor whose peripherals sit in a separate space of 4096 single-bit locations. The processor hands it a command, the value of its base-address register, a signed 8-bit displacement, a 4-bit count and a 16-bit data word. The block then walks the bus one bit at a time. It drives a 12-bit bit address and a data-out line, and it pulses a one-cycle strobe for each bit. On that strobe it samples the data-in line.

Single-bit commands touch one location: the base plus the displacement. Multi-bit commands move a whole field serially, least-significant bit first, and step the address once per bit. A count of zero means sixteen bits. Counts of one to eight work on the upper byte of the data word, and larger counts work on the whole word. When the last bit is done, the block pulses `done` and presents the gathered input word or the tested bit. Locations with no device behind them read as 1s, because the bus floats high.

Top module: `serial_io_ctrl`

## Requirements
- R1: A `start` pulse while `busy` is low, with `cmd` set to 0 (set one), 1 (set zero), 2 (test), 3 (load multi-bit) or 4 (store multi-bit), begins a transfer with `busy` high in the next cycle. A `start` while `busy` is high is ignored, and so is a `cmd` value of 5 to 7.
- R2: A single-bit command uses one address: `base_reg[12:1]` plus the sign-extended `disp`, modulo 4096.
- R3: A multi-bit command uses address `base_reg[12:1]` for its first bit. The address rises by one for each later bit and wraps modulo 4096.
- R4: Each bit takes two cycles. In the first, `strobe` is low. In the second, `strobe` is high. `addr` and `sout` hold the same values across both cycles.
- R5: For multi-bit commands, a `count` of 0 moves 16 bits, and any other value moves exactly `count` bits.
- R6: A count of 1 to 8 is byte-oriented: bit i comes from `wdata[8+i]` or goes to `rdata[8+i]`. Any other count is word-oriented and uses bit i. Bit 0 is moved first.
- R7: During its bit, set one drives `sout` to 1 and set zero drives it to 0. Test and store drive `sout` to 0. `sout` is 0 whenever the block is idle.
- R8: The test command copies the `sin` value sampled on its strobe into `eq_flag`. `eq_flag` keeps its value through every other command.
- R9: A store leaves every `rdata` bit that was not received at 0. Bits read from a location that does not respond (with `sin` held at 1) come back as 1.
- R10: `done` is high for exactly one cycle, the cycle after the last strobe, and `busy` is low in that cycle. `rdata` changes only at the end of a store and then holds its value.
- R11: After reset, `busy`, `done`, `strobe`, `sout`, `rdata` and `eq_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (taken only when idle) |
| cmd | input | 3 | Command code, 0 to 4 |
| base_reg | input | 16 | Base-address register value; bits 12:1 give the base |
| disp | input | 8 | Signed displacement for single-bit commands |
| count | input | 4 | Bit count for multi-bit commands, 0 means 16 |
| wdata | input | 16 | Word to shift out on a load |
| sin | input | 1 | Serial data in from the addressed location |
| addr | output | 12 | Current bit address |
| sout | output | 1 | Serial data out |
| strobe | output | 1 | One-cycle bit clock |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Gathered input word from the last store |
| eq_flag | output | 1 | Bit sampled by the last test |

## Verification
The bench aims at these corner cases:
- Negative displacements and wrap below address zero. A wrong sign extension sends the bit to a far address.
- Counts of 0, 8 and 9 around the byte/word boundary. Picking the wrong data half moves the wrong bits or drops bits on the wrong side of the result.
- A multi-bit walk that wraps past address 4095, and stores from locations that do not respond. These show a missing wrap or stale high-order result bits.
- Mid-transfer `start` pulses and illegal command codes. They catch a controller that restarts or changes course when it should keep going.

// File: rtl/serial_io_ctrl.sv
module serial_io_ctrl #(
  parameter int AW = 12,
  parameter int DW = 16,
  localparam int CW = $clog2(DW),
  localparam int IW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    cmd,
  input  logic [DW-1:0] base_reg,
  input  logic [7:0]    disp,
  input  logic [CW-1:0] count,
  input  logic [DW-1:0] wdata,
  input  logic          sin,
  output logic [AW-1:0] addr,
  output logic          sout,
  output logic          strobe,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          eq_flag
);
  localparam logic [2:0] OP_SET1 = 3'd0, OP_SET0 = 3'd1, OP_TEST = 3'd2,
                         OP_LOAD = 3'd3, OP_STORE = 3'd4;

  logic          ph_q, byte_q;
  logic [2:0]    op_q;
  logic [IW-1:0] idx_q, last_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] sh_q, acc_q, sh0;

  wire go    = start & ~busy & (cmd <= OP_STORE);
  wire multi = (cmd == OP_LOAD) | (cmd == OP_STORE);
  wire [IW-1:0] nbits = (count == '0) ? IW'(DW) : IW'(count);
  wire bytew = multi && (count != '0) && (count <= CW'(DW / 2));
  wire [AW-1:0] a0 = base_reg[AW:1] + (multi ? '0 : {{(AW-8){disp[7]}}, disp});
  wire [DW-1:0] acc_nx = acc_q | (DW'(sin) << idx_q);
  wire last = (idx_q == last_q);

  always_comb begin
    case (cmd)
      OP_SET1: sh0 = '1;
      OP_LOAD: sh0 = bytew ? (wdata >> (DW / 2)) : wdata;
      default: sh0 = '0;
    endcase
  end

  assign addr   = addr_q;
  assign strobe = busy & ph_q;
  assign sout   = busy & sh_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; ph_q <= 1'b0; byte_q <= 1'b0;
      op_q <= OP_SET1; idx_q <= '0; last_q <= '0; addr_q <= '0;
      sh_q <= '0; acc_q <= '0; rdata <= '0; eq_flag <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy   <= 1'b1;
        ph_q   <= 1'b0;
        op_q   <= cmd;
        byte_q <= bytew;
        idx_q  <= '0;
        last_q <= multi ? nbits - IW'(1) : '0;
        addr_q <= a0;
        sh_q   <= sh0;
        acc_q  <= '0;
      end else if (busy) begin
        if (!ph_q) begin
          ph_q <= 1'b1;
        end else begin
          ph_q  <= 1'b0;
          acc_q <= acc_nx;
          if (last) begin
            busy <= 1'b0;
            done <= 1'b1;
            if (op_q == OP_STORE) rdata <= byte_q ? (acc_nx << (DW / 2)) : acc_nx;
            if (op_q == OP_TEST)  eq_flag <= sin;
          end else begin
            idx_q  <= idx_q + IW'(1);
            addr_q <= addr_q + AW'(1);
            sh_q   <= sh_q >> 1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/serial_io_ctrl_chk.sv
module serial_io_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [2:0]  cmd,
  input logic [15:0] base_reg,
  input logic [7:0]  disp,
  input logic [11:0] addr,
  input logic        sout,
  input logic        strobe,
  input logic        busy,
  input logic        done
);
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cmd <= 3'd4) |=> busy);

  p_bad_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cmd > 3'd4) |=> !busy);

  p_single_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cmd <= 3'd2) |=>
      addr == $past(base_reg[12:1]) + {{4{$past(disp[7])}}, $past(disp)});

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (busy -> addr == $past(addr) + 12'd1));

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  p_first_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !strobe);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> ($stable(addr) && $stable(sout) && $past(busy)));

  p_idle_sout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sout);

  p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(strobe)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind serial_io_ctrl serial_io_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .base_reg(base_reg),
  .disp(disp), .addr(addr), .sout(sout), .strobe(strobe), .busy(busy), .done(done)
);

// File: tb/sim_serial_io_ctrl.sv
`timescale 1ns/1ps
module sim_serial_io_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [15:0] base = 16'd0, wd = 16'd0;
  logic [7:0]  disp = 8'd0;
  logic [3:0]  cnt = 4'd0;
  logic        sin;
  logic [11:0] addr;
  logic        sout, strobe, busy, done, eq_flag;
  logic [15:0] rdata;

  int errs = 0, checks = 0;
  bit fin = 1'b0;
  bit periph [4096];
  logic [15:0] exp_rd = 16'd0;
  logic        exp_eq = 1'b0;

  always #2.5 clk = ~clk;

  serial_io_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .base_reg(base),
    .disp(disp), .count(cnt), .wdata(wd), .sin(sin), .addr(addr), .sout(sout),
    .strobe(strobe), .busy(busy), .done(done), .rdata(rdata), .eq_flag(eq_flag)
  );

  function automatic bit pbit(input int a);
    return (a < 'hC00) ? periph[a] : 1'b1;
  endfunction

  always_comb sin = pbit(int'(addr));

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // cmd codes: 0 set one, 1 set zero, 2 test, 3 load, 4 store
  task automatic run(input logic [2:0] c, input logic [15:0] b, input logic [7:0] d,
                     input logic [3:0] n, input logic [15:0] w, input string tag,
                     input bit poke);
    bit multi, by;
    int nb, a;
    logic [15:0] rd;
    multi = (c == 3'd3) || (c == 3'd4);
    nb = multi ? ((n == 0) ? 16 : int'(n)) : 1;
    by = multi && (n != 0) && (n <= 8);
    a = int'(b[12:1]) + (multi ? 0 : int'($signed(d)));
    rd = 16'd0;
    cmd = c; base = b; disp = d; cnt = n; wd = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < nb; i++) begin
      int ai;
      bit s;
      ai = (a + i) & 'hFFF;
      s = (c == 3'd0) ? 1'b1 : (c == 3'd3) ? (by ? w[8+i] : w[i]) : 1'b0;
      chk(busy && !strobe && !done && addr == 12'(ai) && sout == s,
          {tag, " R4 present"}, "busy,strb,done,sout,addr",
          {busy, strobe, done, sout, addr}, {4'b1000 | 4'(s), 12'(ai)});
      if (poke && i == 0) begin start = 1'b1; cmd = 3'd0; base = 16'h0; end
      @(negedge clk);
      start = 1'b0;
      chk(busy && strobe && !done && addr == 12'(ai) && sout == s,
          {tag, " R4 strobe"}, "busy,strb,done,sout,addr",
          {busy, strobe, done, sout, addr}, {4'b1100 | 4'(s), 12'(ai)});
      if (c == 3'd4) rd[by ? 8 + i : i] = pbit(ai);
      if (c == 3'd2) exp_eq = pbit(ai);
      @(negedge clk);
    end
    if (c == 3'd4) exp_rd = rd;
    chk(done && !busy && !strobe, {tag, " R10 done"}, "busy,strb,done",
        {busy, strobe, done}, 3'b001);
    chk(rdata == exp_rd, {tag, " R9 rdata"}, "rdata", rdata, exp_rd);
    chk(eq_flag == exp_eq, {tag, " R8 eq"}, "eq_flag", eq_flag, exp_eq);
    @(negedge clk);
    chk(!done && !busy, {tag, " R10 after"}, "busy,done", {busy, done}, 2'b00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      errs++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) periph[i] = ((i ^ (i >> 3) ^ (i >> 6)) & 1) != 0;
    periph[100] = 1'b1;
    periph[101] = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !strobe && !sout && rdata == 16'd0 && !eq_flag,
        "R11", "reset outputs", {busy, done, strobe, sout, rdata, eq_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(3'd0, 16'h0040, 8'h05, 4'd0, 16'h0, "R7 R2 set1", 1'b0);
    run(3'd1, 16'h0040, 8'hF0, 4'd0, 16'h0, "R7 R2 set0 neg", 1'b0);
    run(3'd0, 16'h0000, 8'hFF, 4'd0, 16'h0, "R2 wrap low", 1'b0);
    run(3'd2, 16'd200,  8'h00, 4'd0, 16'h0, "R8 test one", 1'b0);
    run(3'd2, 16'd200,  8'h01, 4'd0, 16'h0, "R8 test zero", 1'b0);
    run(3'd3, 16'h0100, 8'h00, 4'd0, 16'hA5C3, "R5 R6 load16", 1'b0);
    run(3'd3, 16'h0100, 8'h00, 4'd5, 16'h1B00, "R6 load byte5", 1'b0);
    run(3'd3, 16'h0100, 8'h00, 4'd8, 16'h5A77, "R6 load byte8", 1'b0);
    run(3'd3, 16'h0100, 8'h00, 4'd9, 16'h03F1, "R6 load word9", 1'b0);
    run(3'd3, 16'h1FFC, 8'h00, 4'd4, 16'h000B, "R3 load wrap", 1'b0);
    run(3'd4, 16'h0222, 8'h00, 4'd0, 16'h0, "R5 R9 store16", 1'b0);
    run(3'd2, 16'd200,  8'h00, 4'd0, 16'h0, "R10 rdata hold", 1'b0);
    run(3'd4, 16'h0222, 8'h00, 4'd3, 16'h0, "R6 R9 store byte3", 1'b0);
    run(3'd4, 16'h0310, 8'h00, 4'd10, 16'h0, "R6 R9 store word10", 1'b0);
    run(3'd4, 16'h1820, 8'h00, 4'd0, 16'h0, "R9 store absent", 1'b0);
    run(3'd4, 16'h1FF0, 8'h00, 4'd0, 16'h0, "R3 R9 store wrap", 1'b0);
    run(3'd3, 16'h0140, 8'h00, 4'd6, 16'h2D00, "R1 poke busy", 1'b1);

    cmd = 3'd5; base = 16'h0040; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!busy && !strobe && !sout, "R1 bad cmd", "busy,strb,sout",
        {busy, strobe, sout}, 3'b000);
    @(negedge clk);
    chk(!done && !busy && rdata == exp_rd && eq_flag == exp_eq, "R1 bad cmd after",
        "done,busy,rdata,eq", {done, busy, rdata, eq_flag}, {2'b00, exp_rd, exp_eq});

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule